// File: doc/BRIEF.md
# DRAM Calibration-Pattern Read Responder

This block is the memory side of a DDR3-style command decoder, written to be synthesizable. Each clock it samples a single-data-rate command bus with a command code, a bank address and a row/column address. Mode-register-set commands are decoded into four mode registers. Those registers set the read latency and decide whether reads come from a small register array or from a fixed training source.

When the training source is enabled, every READ is answered with an eight-beat burst that alternates low and high. Each beat fills the whole data lane. The burst order is fixed and the address is ignored. WRITE commands are refused while the source is enabled. Each refused WRITE is dropped and sets a sticky error flag. When the enable bit is cleared, reads and writes go to the array again. Read data begins AL + CL cycles after the READ. AL and CL are looked up from fields of two of the mode registers.

Top module: `mpr_read_responder`

## Requirements
- R1: Command codes are NOP=0, MRS=1, READ=2, WRITE=3. An MRS with bank 3'b000, 3'b001, 3'b010 or 3'b011 loads all fourteen address bits into mode register 0, 1, 2 or 3. An MRS with bank bit 2 set changes no register.
- R2: CL = min(5 + MR0[6:4], 11). AL is CL-1 when MR1[4:3]=01, CL-2 when it is 10, and 0 otherwise. RL = AL + CL. The first beat of a READ is on `dq` in the cycle after the RL-th rising edge that follows the edge sampling the READ. `dq_valid` is low one cycle earlier.
- R3: When MR3[2]=1 and MR3[1:0]=00, a READ returns eight beats 00,FF,00,FF,00,FF,00,FF. Each beat is replicated across all lane bits.
- R4: In that mode the burst content and order do not depend on any address bit of the READ.
- R5: When MR3[2]=1 and MR3[1:0] is not 00, a READ returns eight all-zero beats.
- R6: A WRITE issued while MR3[2]=1 leaves the array unchanged and sets `wr_err` one edge later. `wr_err` then stays high until reset.
- R7: When MR3[2]=0, a WRITE stores `wr_data` into entry addr[3:0]. A READ returns eight beats, where beat k is entry (addr[3:0]+k) mod 16.
- R8: After MR3[2] is cleared, reads return array contents again and writes take effect.
- R9: Each READ gives exactly eight consecutive cycles of `dq_valid`. `dq` is zero whenever `dq_valid` is low.
- R10: After reset all mode registers are zero (RL=5, array reads), the array holds zeros, and `wr_err` and `dq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 2 | Command code sampled each edge |
| cmd_bank | input | 3 | Bank address; selects the mode register on MRS |
| cmd_addr | input | 14 | Row/column address; MRS payload or array index |
| wr_data | input | 8 | Byte stored by a WRITE in array mode |
| dq_valid | output | 1 | High while a burst beat is on `dq` |
| dq | output | 8 | Burst data, one beat per cycle |
| wr_err | output | 1 | Sticky flag for a WRITE refused in training mode |

## Verification
The bench goes through every CL code, including code 7, where the sum must clamp to 11. A design without the clamp starts that burst one cycle late. Each CL code is paired with each AL choice. The bench checks that `dq_valid` is low exactly one cycle before the first beat, so an off-by-one in the latency pipeline shows up as a valid flag that rises early or a first beat that is missing. Training reads are issued with random address bits and with a nonzero select. A design that lets address bits reach the burst, or that ignores the select, returns array bytes or the alternating pattern where none is expected. WRITEs in training mode are followed by an exit and a read-back of the same entry, which exposes a write that was not dropped. MRS commands to banks 4 to 7 carry payloads that would switch modes if they were decoded, so a partial bank decode changes the latency or the data source.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_MRS   = 2'd1,
      CMD_READ  = 2'd2,
      CMD_WRITE = 2'd3
   } cmd_e;

   localparam int BURST_LEN  = 8;
   localparam int BEAT_W     = 3;
   // field positions inside the mode registers
   localparam int CL_LSB     = 4;
   localparam int CL_FLD_W   = 3;
   localparam int AL_LSB     = 3;
   localparam int AL_FLD_W   = 2;
   localparam int MPR_EN_BIT = 2;
endpackage

// File: rtl/mr_file.sv
module mr_file
   import mpr_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int CL_MIN = 5,
   parameter int CL_MAX = 11,
   parameter int RLW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrs_en,
   input  logic [2:0]        bank,
   input  logic [ADDR_W-1:0] addr,
   output logic [RLW-1:0]    rl,
   output logic              mpr_on,
   output logic              mpr_sel_nz
);
   logic [ADDR_W-1:0] mreg [4];
   logic [RLW-1:0]    cl_raw, cl, al;
   logic [AL_FLD_W-1:0] al_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) mreg[i] <= '0;
      end else if (mrs_en && !bank[2]) begin
         mreg[bank[1:0]] <= addr;
      end
   end

   assign cl_raw  = RLW'(CL_MIN) + RLW'(mreg[0][CL_LSB +: CL_FLD_W]);
   assign cl      = (cl_raw > RLW'(CL_MAX)) ? RLW'(CL_MAX) : cl_raw;
   assign al_code = mreg[1][AL_LSB +: AL_FLD_W];

   always_comb begin
      case (al_code)
         2'b01:   al = cl - RLW'(1);
         2'b10:   al = cl - RLW'(2);
         default: al = '0;
      endcase
   end

   assign rl         = al + cl;
   assign mpr_on     = mreg[3][MPR_EN_BIT];
   assign mpr_sel_nz = |mreg[3][1:0];

   logic unused_mreg_bits;
   assign unused_mreg_bits = ^{mreg[0], mreg[1], mreg[2], mreg[3]};
endmodule

// File: rtl/data_array.sv
module data_array #(
   parameter int    DW     = 8,
   parameter int    DEPTH  = 16,
   parameter bit    RST_EN = 1'b1,
   localparam int   IDXW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] w_idx,
   input  logic [DW-1:0]   w_data,
   input  logic [IDXW-1:0] r_idx,
   output logic [DW-1:0]   r_data
);
   logic [DW-1:0] mem [DEPTH];

   if (RST_EN) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[w_idx] <= w_data;
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (we) mem[w_idx] <= w_data;
      end
      logic unused_rst;
      assign unused_rst = rst_n;
   end

   assign r_data = mem[r_idx];
endmodule

// File: rtl/lat_pipe.sv
module lat_pipe #(
   parameter int  MAX_RL = 21,
   parameter int  RLW    = 5,
   parameter int  IDXW   = 4,
   localparam int TAGW   = IDXW + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins,
   input  logic [RLW-1:0]  ins_rl,
   input  logic            ins_mpr,
   input  logic            ins_zero,
   input  logic [IDXW-1:0] ins_idx,
   output logic            out_valid,
   output logic            out_mpr,
   output logic            out_zero,
   output logic [IDXW-1:0] out_idx
);
   logic [MAX_RL-1:0][TAGW-1:0] slot, nxt;
   logic [TAGW-1:0]             ins_tag;

   assign ins_tag = {1'b1, ins_mpr, ins_zero, ins_idx};

   for (genvar i = 0; i < MAX_RL; i++) begin : g_slot
      logic hit;
      assign hit = ins && (ins_rl == RLW'(i + 1));
      if (i == MAX_RL - 1) begin : g_top
         assign nxt[i] = hit ? ins_tag : '0;
      end else begin : g_mid
         assign nxt[i] = hit ? ins_tag : slot[i+1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) slot <= '0;
      else        slot <= nxt;
   end

   assign {out_valid, out_mpr, out_zero, out_idx} = slot[0];
endmodule

// File: rtl/burst_out.sv
module burst_out
   import mpr_pkg::*;
#(
   parameter int DW   = 8,
   parameter int IDXW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            s_mpr,
   input  logic            s_zero,
   input  logic [IDXW-1:0] s_idx,
   input  logic [DW-1:0]   rd_data,
   output logic [IDXW-1:0] rd_idx,
   output logic            dq_valid,
   output logic [DW-1:0]   dq
);
   logic              busy, cur_mpr, cur_zero;
   logic [BEAT_W-1:0] beat, eff_beat;
   logic [IDXW-1:0]   cur_idx;
   logic              eff_mpr, eff_zero;
   logic [DW-1:0]     beat_val;

   assign eff_mpr  = start ? s_mpr  : cur_mpr;
   assign eff_zero = start ? s_zero : cur_zero;
   assign eff_beat = start ? '0     : beat;
   assign rd_idx   = start ? s_idx  : cur_idx + IDXW'(beat);
   assign beat_val = !eff_mpr ? rd_data :
                     (eff_zero ? '0 : {DW{eff_beat[0]}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         beat     <= '0;
         cur_mpr  <= 1'b0;
         cur_zero <= 1'b0;
         cur_idx  <= '0;
         dq_valid <= 1'b0;
         dq       <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         beat     <= BEAT_W'(1);
         cur_mpr  <= s_mpr;
         cur_zero <= s_zero;
         cur_idx  <= s_idx;
         dq_valid <= 1'b1;
         dq       <= beat_val;
      end else if (busy) begin
         beat     <= beat + BEAT_W'(1);
         busy     <= (beat != BEAT_W'(BURST_LEN - 1));
         dq_valid <= 1'b1;
         dq       <= beat_val;
      end else begin
         dq_valid <= 1'b0;
         dq       <= '0;
      end
   end
endmodule

// File: rtl/mpr_read_responder.sv
module mpr_read_responder
   import mpr_pkg::*;
#(
   parameter int  DQ_W      = 8,
   parameter int  ADDR_W    = 14,
   parameter int  ARR_DEPTH = 16,
   parameter bit  ARR_RESET = 1'b1,
   parameter int  CL_MIN    = 5,
   parameter int  CL_MAX    = 11,
   localparam int MAX_RL    = 2 * CL_MAX - 1,
   localparam int RLW       = $clog2(MAX_RL + 1),
   localparam int IDXW      = $clog2(ARR_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_code,
   input  logic [2:0]        cmd_bank,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DQ_W-1:0]   wr_data,
   output logic              dq_valid,
   output logic [DQ_W-1:0]   dq,
   output logic              wr_err
);
   if ((ARR_DEPTH & (ARR_DEPTH - 1)) != 0 || ARR_DEPTH < 2) begin : g_bad_depth
      $error("ARR_DEPTH must be a power of two of at least 2");
   end
   if (CL_MIN < 3 || CL_MAX < CL_MIN) begin : g_bad_cl
      $error("CL range must satisfy 3 <= CL_MIN <= CL_MAX");
   end
   if (ADDR_W < 13 || IDXW > ADDR_W) begin : g_bad_addr
      $error("address bus too narrow");
   end

   cmd_e              cmd;
   logic              is_mrs, is_rd, is_wr;
   logic [RLW-1:0]    rl;
   logic              mpr_on, mpr_sel_nz;
   logic              p_valid, p_mpr, p_zero;
   logic [IDXW-1:0]   p_idx, rd_idx;
   logic [DQ_W-1:0]   rd_data;

   assign cmd    = cmd_e'(cmd_code);
   assign is_mrs = (cmd == CMD_MRS);
   assign is_rd  = (cmd == CMD_READ);
   assign is_wr  = (cmd == CMD_WRITE);

   mr_file #(.ADDR_W(ADDR_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .RLW(RLW)) u_mr (
      .clk(clk), .rst_n(rst_n), .mrs_en(is_mrs), .bank(cmd_bank), .addr(cmd_addr),
      .rl(rl), .mpr_on(mpr_on), .mpr_sel_nz(mpr_sel_nz)
   );

   data_array #(.DW(DQ_W), .DEPTH(ARR_DEPTH), .RST_EN(ARR_RESET)) u_arr (
      .clk(clk), .rst_n(rst_n), .we(is_wr && !mpr_on), .w_idx(cmd_addr[IDXW-1:0]),
      .w_data(wr_data), .r_idx(rd_idx), .r_data(rd_data)
   );

   lat_pipe #(.MAX_RL(MAX_RL), .RLW(RLW), .IDXW(IDXW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .ins(is_rd), .ins_rl(rl), .ins_mpr(mpr_on),
      .ins_zero(mpr_sel_nz), .ins_idx(cmd_addr[IDXW-1:0]),
      .out_valid(p_valid), .out_mpr(p_mpr), .out_zero(p_zero), .out_idx(p_idx)
   );

   burst_out #(.DW(DQ_W), .IDXW(IDXW)) u_burst (
      .clk(clk), .rst_n(rst_n), .start(p_valid), .s_mpr(p_mpr), .s_zero(p_zero),
      .s_idx(p_idx), .rd_data(rd_data), .rd_idx(rd_idx), .dq_valid(dq_valid), .dq(dq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                wr_err <= 1'b0;
      else if (is_wr && mpr_on)  wr_err <= 1'b1;
   end
endmodule

// File: rtl/mpr_read_responder_chk.sv
module mpr_read_responder_chk #(
   parameter int DQ_W = 8,
   parameter int RLW  = 5,
   parameter int CL_MIN = 5,
   parameter int MAX_RL = 21
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      cmd_code,
   input logic            mpr_on,
   input logic [RLW-1:0]  rl,
   input logic            dq_valid,
   input logic [DQ_W-1:0] dq,
   input logic            wr_err,
   input logic            cur_mpr,
   input logic            cur_zero
);
   logic [5:0] run;
   always_ff @(posedge clk) begin
      if (!rst_n)        run <= '0;
      else if (dq_valid) run <= (run == 6'd63) ? run : run + 6'd1;
      else               run <= '0;
   end

   p_wr_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);
   p_write_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == 2'd3 && mpr_on) |=> wr_err);
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_valid |-> (dq == '0));
   p_burst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dq_valid && run != 6'd0) |-> (run[2:0] == 3'd0));
   p_mpr_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && cur_mpr && !cur_zero) |-> (dq == '0 || dq == '1));
   p_sel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && cur_mpr && cur_zero) |-> (dq == '0));
   p_rl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rl >= RLW'(CL_MIN) && rl <= RLW'(MAX_RL)));
endmodule

bind mpr_read_responder mpr_read_responder_chk #(
   .DQ_W(DQ_W), .RLW(RLW), .CL_MIN(CL_MIN), .MAX_RL(MAX_RL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .mpr_on(mpr_on), .rl(rl),
   .dq_valid(dq_valid), .dq(dq), .wr_err(wr_err),
   .cur_mpr(u_burst.cur_mpr), .cur_zero(u_burst.cur_zero)
);

// File: tb/mpr_read_responder_test.sv
module mpr_read_responder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd_code = 2'd0;
   logic [2:0]  cmd_bank = 3'd0;
   logic [13:0] cmd_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        dq_valid, wr_err;
   logic [7:0]  dq;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [7:0]  m [16];
   logic [13:0] mr [4];
   logic        err_exp = 1'b0;

   always #5 clk = ~clk;

   mpr_read_responder uut (
      .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .wr_data(wr_data), .dq_valid(dq_valid), .dq(dq),
      .wr_err(wr_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_rl();
      int cl, al;
      cl = 5 + int'(mr[0][6:4]);
      if (cl > 11) cl = 11;
      case (mr[1][4:3])
         2'b01:   al = cl - 1;
         2'b10:   al = cl - 2;
         default: al = 0;
      endcase
      return al + cl;
   endfunction

   function automatic logic [7:0] exp_beat(input logic [13:0] a, input int k);
      if (mr[3][2]) begin
         if (mr[3][1:0] != 2'b00) return 8'h00;
         return (k % 2 == 1) ? 8'hFF : 8'h00;
      end
      return m[(int'(a[3:0]) + k) % 16];
   endfunction

   task automatic issue(input logic [1:0] c, input logic [2:0] b,
                        input logic [13:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_code = c; cmd_bank = b; cmd_addr = a; wr_data = d;
      @(negedge clk);
      cmd_code = 2'd0; cmd_bank = 3'd0; cmd_addr = '0; wr_data = '0;
   endtask

   task automatic mrs(input logic [2:0] b, input logic [13:0] a);
      issue(2'd1, b, a, 8'h00);
      if (!b[2]) mr[b[1:0]] = a;   // R1: banks 4..7 change nothing
   endtask

   task automatic wr(input logic [13:0] a, input logic [7:0] d);
      issue(2'd3, 3'd0, a, d);
      if (mr[3][2]) err_exp = 1'b1; else m[a[3:0]] = d;
      chk(wr_err == err_exp, "R6 wr_err after write", int'(wr_err), int'(err_exp));
   endtask

   task automatic rd(input logic [13:0] a, input string req);
      int rl;
      logic [7:0] e;
      rl = exp_rl();
      issue(2'd2, 3'd0, a, 8'h00);
      repeat (rl - 1) @(negedge clk);
      chk(dq_valid == 1'b0, {req, " R2 valid low before first beat"}, int'(dq_valid), 0);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         e = exp_beat(a, k);
         chk(dq_valid == 1'b1 && dq == e, {req, " beat data"}, int'({dq_valid, dq}), int'({1'b1, e}));
      end
      @(negedge clk);
      chk(dq_valid == 1'b0 && dq == 8'h00, "R9 idle after eight beats", int'({dq_valid, dq}), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 16; i++) m[i] = 8'h00;
      for (int i = 0; i < 4; i++) mr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(dq_valid == 1'b0 && dq == 8'h00, "R10 outputs after reset", int'({dq_valid, dq}), 0);
      chk(wr_err == 1'b0, "R10 wr_err after reset", int'(wr_err), 0);
      rd(14'h0005, "R10 zero array RL=5");

      // R7 normal writes and wrapped read order
      for (int i = 0; i < 16; i++) wr(14'(i), 8'(8'h11 * i + 3));
      rd(14'h000D, "R7 wrap read");
      rd(14'h1FF2, "R7 upper bits ignored");

      // R2 every CL code against every AL choice
      for (int c = 0; c < 8; c++) begin
         for (int a = 0; a < 4; a++) begin
            mrs(3'd0, 14'(c << 4));
            mrs(3'd1, 14'(a << 3));
            rd(14'(c * 3 + a), "R2 latency sweep");
         end
      end

      // R3 / R4 training pattern with varied address bits
      mrs(3'd3, 14'h0004);
      rd(14'h1000, "R3 pattern");
      rd(14'h3FFF, "R4 address ignored");
      rd(14'h0007, "R4 low bits ignored");

      // R6 write refused
      wr(14'h0003, 8'hA5);
      wr(14'h0004, 8'h5A);

      // R5 nonzero select
      mrs(3'd3, 14'h0006);
      rd(14'h1000, "R5 zero burst");
      wr(14'h0008, 8'hC3);

      // R8 exit training mode, array untouched
      mrs(3'd3, 14'h0003);
      rd(14'h0003, "R8 back to array");
      wr(14'h0003, 8'h77);
      rd(14'h0002, "R8 writes active again");
      chk(wr_err == 1'b1, "R6 wr_err sticky", int'(wr_err), 1);

      // R1 banks 4..7 ignored
      mrs(3'd7, 14'h0004);
      mrs(3'd4, 14'h0070);
      mrs(3'd5, 14'h0010);
      rd(14'h0001, "R1 high banks ignored");
      mrs(3'd2, 14'h0004);
      rd(14'h0001, "R1 MR2 not MR3");

      // random mix
      for (int it = 0; it < 250; it++) begin
         int op;
         op = int'($urandom_range(0, 6));
         case (op)
            0, 1: wr(14'($urandom()), 8'($urandom()));
            2, 3: rd(14'($urandom()), "R3 R7 random read");
            4:    mrs(3'd0, 14'($urandom()));
            5:    mrs(3'd1, 14'($urandom()));
            default: mrs(3'd3, 14'($urandom_range(0, 7)));
         endcase
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule